// File: doc/BRIEF.md
# Isochronous OUT Endpoint Tracker

This block follows one high-speed isochronous OUT endpoint through a microframe. Software arms it with a transfer size, an initial packet count and an even/odd microframe selector, together with a single strobe that both enables the endpoint and clears its NAK state. After that, the USB receive path reports each received data packet. For every packet it gives the token status, the data PID, the CRC result, the byte count and the free space left in the receive FIFO.

For each packet the tracker either accepts it or drops it. An accepted packet lowers the remaining packet count and the remaining byte count and records its PID. When the transfer ends, the tracker raises a sticky transfer-complete flag and clears the enable. It also computes a data-valid flag by comparing the final PID with the number of packets actually received. If the end of the periodic frame arrives first, it raises a sticky incomplete-transfer flag instead. In that case the endpoint stays enabled but is no longer active on the bus. The completion flag only says that the transfer ended; the data-valid flag says whether the data can be trusted.

Top module: `iso_out_ep_tracker`

## Requirements
- R1: After reset, ep_en, xfer_active, pkt_accept, pkt_drop, xfrc_irq, incomp_irq and data_valid are 0, and rem_pkts, rem_size and last_pid are 0.
- R2: A cycle with arm_go high loads rem_size from arm_size, rem_pkts from arm_pkts and the parity from arm_odd. It sets ep_en and xfer_active to 1 and clears data_valid and last_pid, all visible on the next cycle.
- R3: A pkt_valid pulse is accepted when all of the following hold: ep_en and xfer_active are 1, frame_odd equals the armed parity, tok_bad is 0, crc_ok is 1, fifo_free >= byte_cnt, and pid is one of DATA0=4'b0011, DATA1=4'b1011, DATA2=4'b0111 or MDATA=4'b1111. On the next cycle pkt_accept is 1 for one cycle and rem_pkts is one lower. rem_size is lower by byte_cnt, saturating at 0, and last_pid holds the packet's PID.
- R4: A pkt_valid pulse that meets the activity and parity conditions but has tok_bad=1, crc_ok=0, fifo_free < byte_cnt or any other PID value is dropped. pkt_drop is 1 for one cycle, and rem_pkts, rem_size and last_pid are unchanged.
- R5: A pkt_valid pulse is ignored when frame_odd differs from the armed parity, or when the endpoint is not both enabled and active. Neither pkt_accept nor pkt_drop pulses, and the counts are unchanged.
- R6: An accepted packet completes the transfer when it brings rem_pkts to 0, or when its byte_cnt is below MAX_PKT (1024). On the next cycle xfrc_irq is 1 and ep_en and xfer_active are 0.
- R7: At completion, data_valid becomes 1 only for these pairs of final PID and packets received (arm_pkts minus the final rem_pkts): DATA0 with 1 packet, DATA1 with 2, or DATA2 with 3. It is 0 for any other pair, including a final MDATA.
- R8: An eof pulse while xfer_active is 1, with no completing packet in the same cycle, sets incomp_irq and clears xfer_active. ep_en stays 1 and xfrc_irq is not set. Later packets are ignored.
- R9: xfrc_irq and incomp_irq stay set until a clr_xfrc or clr_incomp strobe clears them. A new set event in the same cycle as its clear strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_go | input | 1 | Enable and clear-NAK strobe; loads the arm values |
| arm_size | input | SIZE_W | Transfer size in bytes |
| arm_pkts | input | PKT_W | Initial packet count |
| arm_odd | input | 1 | Microframe parity selector (1 = odd) |
| frame_odd | input | 1 | LSB of the current microframe number |
| eof | input | 1 | End of periodic frame pulse |
| pkt_valid | input | 1 | Packet end strobe; qualifies the packet fields |
| tok_bad | input | 1 | The OUT token arrived corrupted |
| pid | input | 4 | Data PID of the packet |
| crc_ok | input | 1 | The data CRC check passed |
| byte_cnt | input | BYTE_W | Payload bytes in the packet |
| fifo_free | input | FIFO_W | Free bytes in the receive FIFO |
| clr_xfrc | input | 1 | Write-one-to-clear for xfrc_irq |
| clr_incomp | input | 1 | Write-one-to-clear for incomp_irq |
| ep_en | output | 1 | Endpoint enabled |
| xfer_active | output | 1 | A transfer is in progress on the bus |
| rem_pkts | output | PKT_W | Remaining packet count |
| rem_size | output | SIZE_W | Remaining transfer size |
| last_pid | output | 4 | PID of the last accepted packet |
| pkt_accept | output | 1 | One-cycle pulse per accepted packet |
| pkt_drop | output | 1 | One-cycle pulse per dropped packet |
| xfrc_irq | output | 1 | Sticky transfer-complete flag |
| incomp_irq | output | 1 | Sticky incomplete-transfer flag |
| data_valid | output | 1 | Received data passed the PID versus packet-count rule |

## Verification
The bench uses the default parameters: a 2-bit packet count, an 11-bit byte count, a 12-bit FIFO level and a 13-bit size. With these values, every initial packet count from 1 to 3 can be combined with every final data PID. Each combination completes either at the programmed count or early on a short packet, and both microframe parities are used, so the full validity table and both completion causes are swept. The same small widths also reach the drop causes, the parity rejection, the end-of-frame path and the clear-versus-set case in a few cycles each.

// File: rtl/iso_trk_pkg.sv
package iso_trk_pkg;
   localparam logic [3:0] PID_DATA0 = 4'b0011;
   localparam logic [3:0] PID_DATA1 = 4'b1011;
   localparam logic [3:0] PID_DATA2 = 4'b0111;
   localparam logic [3:0] PID_MDATA = 4'b1111;

   function automatic logic is_data_pid(input logic [3:0] p);
      return (p == PID_DATA0) || (p == PID_DATA1) ||
             (p == PID_DATA2) || (p == PID_MDATA);
   endfunction
endpackage

// File: rtl/iso_pkt_filter.sv
module iso_pkt_filter import iso_trk_pkg::*; #(
   parameter int BYTE_W     = 11,
   parameter int FIFO_W     = 12,
   parameter int MAX_PKT    = 1024,
   parameter bit STRICT_PID = 1'b1
) (
   input  logic              en,
   input  logic              active,
   input  logic              parity,
   input  logic              frame_odd,
   input  logic              pkt_valid,
   input  logic              tok_bad,
   input  logic [3:0]        pid,
   input  logic              crc_ok,
   input  logic [BYTE_W-1:0] byte_cnt,
   input  logic [FIFO_W-1:0] fifo_free,
   output logic              acc,
   output logic              drop,
   output logic              short_pkt
);
   localparam int CW = (FIFO_W > BYTE_W) ? FIFO_W : BYTE_W;

   initial begin
      assert (MAX_PKT < (1 << BYTE_W)) else $error("BYTE_W too narrow for MAX_PKT");
   end

   logic seen, fits, pid_ok, good;

   generate
      if (STRICT_PID) begin : g_strict
         assign pid_ok = is_data_pid(pid);
      end else begin : g_loose
         assign pid_ok = 1'b1;
      end
   endgenerate

   assign seen      = pkt_valid & en & active & (frame_odd == parity);
   assign fits      = CW'(fifo_free) >= CW'(byte_cnt);
   assign good      = ~tok_bad & crc_ok & fits & pid_ok;
   assign acc       = seen & good;
   assign drop      = seen & ~good;
   assign short_pkt = byte_cnt < BYTE_W'(MAX_PKT);
endmodule

// File: rtl/iso_xfer_counter.sv
module iso_xfer_counter import iso_trk_pkg::*; #(
   parameter int SIZE_W = 13,
   parameter int PKT_W  = 2,
   parameter int BYTE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [SIZE_W-1:0] arm_size,
   input  logic [PKT_W-1:0]  arm_pkts,
   input  logic              arm_odd,
   input  logic              acc,
   input  logic [3:0]        pid,
   input  logic [BYTE_W-1:0] byte_cnt,
   input  logic              short_pkt,
   input  logic              eof,
   output logic              en,
   output logic              active,
   output logic              parity,
   output logic [PKT_W-1:0]  rem_pkts,
   output logic [SIZE_W-1:0] rem_size,
   output logic [3:0]        last_pid,
   output logic              valid_q,
   output logic              done_set,
   output logic              incomp_set
);
   initial begin
      assert (PKT_W >= 2) else $error("PKT_W must be at least 2");
      assert (BYTE_W <= SIZE_W) else $error("BYTE_W must not exceed SIZE_W");
   end

   logic [PKT_W-1:0]  init_pkts;
   logic [PKT_W-1:0]  rem_dec;
   logic [PKT_W-1:0]  rcv;
   logic [SIZE_W-1:0] bytes_ext;
   logic [SIZE_W-1:0] size_next;
   logic              finish;
   logic              pid_match;

   assign rem_dec   = rem_pkts - 1'b1;
   assign rcv       = init_pkts - rem_dec;
   assign bytes_ext = SIZE_W'(byte_cnt);
   assign size_next = (rem_size >= bytes_ext) ? (rem_size - bytes_ext) : '0;
   assign finish    = acc & ((rem_pkts == PKT_W'(1)) | short_pkt);
   assign pid_match = ((pid == PID_DATA0) && (rcv == PKT_W'(1))) ||
                      ((pid == PID_DATA1) && (rcv == PKT_W'(2))) ||
                      ((pid == PID_DATA2) && (rcv == PKT_W'(3)));

   assign done_set   = ~arm & finish;
   assign incomp_set = ~arm & eof & active & ~finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         active    <= 1'b0;
         parity    <= 1'b0;
         init_pkts <= '0;
         rem_pkts  <= '0;
         rem_size  <= '0;
         last_pid  <= '0;
         valid_q   <= 1'b0;
      end else if (arm) begin
         en        <= 1'b1;
         active    <= 1'b1;
         parity    <= arm_odd;
         init_pkts <= arm_pkts;
         rem_pkts  <= arm_pkts;
         rem_size  <= arm_size;
         last_pid  <= '0;
         valid_q   <= 1'b0;
      end else begin
         if (acc) begin
            rem_pkts <= rem_dec;
            rem_size <= size_next;
            last_pid <= pid;
         end
         if (finish) begin
            en      <= 1'b0;
            active  <= 1'b0;
            valid_q <= pid_match;
         end else if (eof && active) begin
            active  <= 1'b0;
         end
      end
   end

   // R3: each accepted packet removes exactly one from the remaining count
   a_r3_accept_steps: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !arm |=> rem_pkts == PKT_W'($past(rem_pkts) - 1'b1));
   // R4 / R5: without an accepted packet, the counts stay put
   a_r4_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc && !arm |=> $stable(rem_pkts) && $stable(rem_size) && $stable(last_pid));
   // R6: a finishing packet leaves the endpoint disabled
   a_r6_finish_disables: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> !en && !active);
   // R7: a valid-data flag only exists once the endpoint has finished
   a_r7_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> !en);
   // R8: an incomplete transfer keeps the endpoint enabled but idle
   a_r8_incomp_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
      incomp_set |=> en && !active);
endmodule

// File: rtl/iso_sticky_flags.sv
module iso_sticky_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   initial begin
      assert (N >= 1) else $error("N must be positive");
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
         end

         // R9: a flag only moves on a set or a clear strobe
         a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !set[i] && !clr[i] |=> $stable(flag[i]));
         // R9: set wins over a simultaneous clear
         a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);
      end
   endgenerate
endmodule

// File: rtl/iso_out_ep_tracker.sv
module iso_out_ep_tracker import iso_trk_pkg::*; #(
   parameter int SIZE_W     = 13,
   parameter int PKT_W      = 2,
   parameter int BYTE_W     = 11,
   parameter int FIFO_W     = 12,
   parameter int MAX_PKT    = 1024,
   parameter bit STRICT_PID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_go,
   input  logic [SIZE_W-1:0] arm_size,
   input  logic [PKT_W-1:0]  arm_pkts,
   input  logic              arm_odd,
   input  logic              frame_odd,
   input  logic              eof,
   input  logic              pkt_valid,
   input  logic              tok_bad,
   input  logic [3:0]        pid,
   input  logic              crc_ok,
   input  logic [BYTE_W-1:0] byte_cnt,
   input  logic [FIFO_W-1:0] fifo_free,
   input  logic              clr_xfrc,
   input  logic              clr_incomp,
   output logic              ep_en,
   output logic              xfer_active,
   output logic [PKT_W-1:0]  rem_pkts,
   output logic [SIZE_W-1:0] rem_size,
   output logic [3:0]        last_pid,
   output logic              pkt_accept,
   output logic              pkt_drop,
   output logic              xfrc_irq,
   output logic              incomp_irq,
   output logic              data_valid
);
   localparam int NFLAGS = 2;

   logic acc, drop, short_pkt, parity;
   logic done_set, incomp_set;
   logic [NFLAGS-1:0] flags;

   iso_pkt_filter #(
      .BYTE_W(BYTE_W), .FIFO_W(FIFO_W), .MAX_PKT(MAX_PKT), .STRICT_PID(STRICT_PID)
   ) filt_i (
      .en(ep_en), .active(xfer_active), .parity(parity), .frame_odd(frame_odd),
      .pkt_valid(pkt_valid), .tok_bad(tok_bad), .pid(pid), .crc_ok(crc_ok),
      .byte_cnt(byte_cnt), .fifo_free(fifo_free),
      .acc(acc), .drop(drop), .short_pkt(short_pkt)
   );

   iso_xfer_counter #(
      .SIZE_W(SIZE_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W)
   ) cnt_i (
      .clk(clk), .rst_n(rst_n), .arm(arm_go), .arm_size(arm_size),
      .arm_pkts(arm_pkts), .arm_odd(arm_odd), .acc(acc), .pid(pid),
      .byte_cnt(byte_cnt), .short_pkt(short_pkt), .eof(eof),
      .en(ep_en), .active(xfer_active), .parity(parity),
      .rem_pkts(rem_pkts), .rem_size(rem_size), .last_pid(last_pid),
      .valid_q(data_valid), .done_set(done_set), .incomp_set(incomp_set)
   );

   iso_sticky_flags #(.N(NFLAGS)) flags_i (
      .clk(clk), .rst_n(rst_n),
      .set({incomp_set, done_set}),
      .clr({clr_incomp, clr_xfrc}),
      .flag(flags)
   );

   assign xfrc_irq   = flags[0];
   assign incomp_irq = flags[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_accept <= 1'b0;
         pkt_drop   <= 1'b0;
      end else begin
         pkt_accept <= acc & ~arm_go;
         pkt_drop   <= drop & ~arm_go;
      end
   end

   // R5: a packet in the other microframe parity produces no pulse
   a_r5_other_parity_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && (frame_odd != parity) |=> !pkt_accept && !pkt_drop);
   // R3 / R4: accept and drop never pulse together
   a_r4_accept_drop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_accept && pkt_drop));
   // R8: an incomplete event never comes with a completion
   a_r8_no_xfrc_on_incomp: assert property (@(posedge clk) disable iff (!rst_n)
      incomp_set |-> !done_set);
endmodule

// File: tb/iso_out_ep_tracker_tb_top.sv
`timescale 1ns/100ps
module iso_out_ep_tracker_tb_top;
   localparam int SIZE_W = 13, PKT_W = 2, BYTE_W = 11, FIFO_W = 12;
   localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011, P_D2 = 4'b0111, P_MD = 4'b1111;

   logic clk = 0, rst_n = 0;
   logic arm_go = 0, arm_odd = 0, frame_odd = 0, eof = 0, pkt_valid = 0;
   logic tok_bad = 0, crc_ok = 1, clr_xfrc = 0, clr_incomp = 0;
   logic [SIZE_W-1:0] arm_size = 0;
   logic [PKT_W-1:0]  arm_pkts = 0;
   logic [3:0]        pid = 0;
   logic [BYTE_W-1:0] byte_cnt = 0;
   logic [FIFO_W-1:0] fifo_free = 0;
   logic ep_en, xfer_active, pkt_accept, pkt_drop, xfrc_irq, incomp_irq, data_valid;
   logic [PKT_W-1:0]  rem_pkts;
   logic [SIZE_W-1:0] rem_size;
   logic [3:0]        last_pid;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   iso_out_ep_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .arm_go(arm_go), .arm_size(arm_size),
      .arm_pkts(arm_pkts), .arm_odd(arm_odd), .frame_odd(frame_odd), .eof(eof),
      .pkt_valid(pkt_valid), .tok_bad(tok_bad), .pid(pid), .crc_ok(crc_ok),
      .byte_cnt(byte_cnt), .fifo_free(fifo_free), .clr_xfrc(clr_xfrc),
      .clr_incomp(clr_incomp), .ep_en(ep_en), .xfer_active(xfer_active),
      .rem_pkts(rem_pkts), .rem_size(rem_size), .last_pid(last_pid),
      .pkt_accept(pkt_accept), .pkt_drop(pkt_drop), .xfrc_irq(xfrc_irq),
      .incomp_irq(incomp_irq), .data_valid(data_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic arm(input int n, input int sz, input bit odd);
      @(negedge clk);
      arm_go = 1; arm_pkts = PKT_W'(n); arm_size = SIZE_W'(sz); arm_odd = odd;
      frame_odd = odd;
      @(negedge clk);
      arm_go = 0;
   endtask

   task automatic send(input logic [3:0] p, input int bytes, input bit crc,
                       input bit tbad, input int ffree, input bit fodd);
      @(negedge clk);
      pkt_valid = 1; pid = p; byte_cnt = BYTE_W'(bytes); crc_ok = crc;
      tok_bad = tbad; fifo_free = FIFO_W'(ffree); frame_odd = fodd;
      @(negedge clk);
      pkt_valid = 0; crc_ok = 1; tok_bad = 0;
   endtask

   task automatic pulse_eof(input bit with_clr);
      @(negedge clk);
      eof = 1; clr_incomp = with_clr;
      @(negedge clk);
      eof = 0; clr_incomp = 0;
   endtask

   task automatic pulse_clr(input bit x, input bit i);
      @(negedge clk);
      clr_xfrc = x; clr_incomp = i;
      @(negedge clk);
      clr_xfrc = 0; clr_incomp = 0;
   endtask

   function automatic int exp_valid(input logic [3:0] p, input int k);
      return ((p == P_D0 && k == 1) || (p == P_D1 && k == 2) || (p == P_D2 && k == 3)) ? 1 : 0;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [3:0] ptab [4];
      ptab[0] = P_D0; ptab[1] = P_D1; ptab[2] = P_D2; ptab[3] = P_MD;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ep_en", ep_en, 0);         chk("R1 active", xfer_active, 0);
      chk("R1 xfrc", xfrc_irq, 0);       chk("R1 incomp", incomp_irq, 0);
      chk("R1 valid", data_valid, 0);    chk("R1 rem_pkts", rem_pkts, 0);
      chk("R1 rem_size", rem_size, 0);   chk("R1 last_pid", last_pid, 0);
      chk("R1 accept", pkt_accept, 0);   chk("R1 drop", pkt_drop, 0);
      rst_n = 1;

      // R6 / R7 sweep: initial count, final PID, completion point
      for (int n = 1; n <= 3; n++) begin
         for (int pi = 0; pi < 4; pi++) begin
            for (int k = 1; k <= n; k++) begin
               bit odd;
               int sz, lastb, exps;
               odd = 1'((n + pi + k) & 1);
               sz = n * 1024;
               arm(n, sz, odd);
               chk("R2 ep_en", ep_en, 1);
               chk("R2 rem_pkts", rem_pkts, n);
               chk("R2 rem_size", rem_size, sz);
               chk("R2 valid cleared", data_valid, 0);
               for (int j = 1; j < k; j++) begin
                  send(P_MD, 1024, 1, 0, 2048, odd);
                  chk("R3 accept", pkt_accept, 1);
                  chk("R3 rem_pkts", rem_pkts, n - j);
                  chk("R3 last_pid", last_pid, P_MD);
               end
               lastb = (k == n) ? 1024 : 200;
               send(ptab[pi], lastb, 1, 0, 2048, odd);
               exps = sz - (k - 1) * 1024 - lastb;
               chk("R3 final accept", pkt_accept, 1);
               chk("R3 final rem_size", rem_size, exps);
               chk("R3 final rem_pkts", rem_pkts, n - k);
               chk("R6 xfrc", xfrc_irq, 1);
               chk("R6 ep_en cleared", ep_en, 0);
               chk("R7 data_valid", data_valid, exp_valid(ptab[pi], k));
               chk("R7 last_pid", last_pid, ptab[pi]);
               chk("R8 no incomp", incomp_irq, 0);
               pulse_clr(1, 0);
               chk("R9 xfrc cleared", xfrc_irq, 0);
            end
         end
      end

      // R4 drop causes
      arm(2, 2048, 0);
      send(P_D0, 1024, 0, 0, 2048, 0);
      chk("R4 crc drop", pkt_drop, 1);  chk("R4 crc no accept", pkt_accept, 0);
      send(P_D0, 1024, 1, 1, 2048, 0);
      chk("R4 token drop", pkt_drop, 1);
      send(P_D0, 1024, 1, 0, 1000, 0);
      chk("R4 fifo drop", pkt_drop, 1);
      send(4'b0001, 1024, 1, 0, 2048, 0);
      chk("R4 pid drop", pkt_drop, 1);
      chk("R4 rem_pkts held", rem_pkts, 2);
      chk("R4 rem_size held", rem_size, 2048);
      chk("R4 last_pid held", last_pid, 0);
      send(P_MD, 1024, 1, 0, 1024, 0);
      chk("R3 exact fit accept", pkt_accept, 1);

      // R5 other parity
      send(P_D1, 1024, 1, 0, 2048, 1);
      chk("R5 parity no accept", pkt_accept, 0);
      chk("R5 parity no drop", pkt_drop, 0);
      chk("R5 parity rem_pkts", rem_pkts, 1);
      send(P_D1, 1024, 1, 0, 2048, 0);
      chk("R7 D1 two pkts", data_valid, 1);
      send(P_D0, 100, 1, 0, 2048, 0);
      chk("R5 disabled no accept", pkt_accept, 0);
      chk("R5 disabled no drop", pkt_drop, 0);
      chk("R5 disabled last_pid", last_pid, P_D1);
      pulse_clr(1, 0);

      // R8 end of frame before completion
      arm(3, 3072, 1);
      send(P_MD, 1024, 1, 0, 2048, 1);
      pulse_eof(0);
      chk("R8 incomp", incomp_irq, 1);
      chk("R8 ep_en kept", ep_en, 1);
      chk("R8 inactive", xfer_active, 0);
      chk("R8 no xfrc", xfrc_irq, 0);
      send(P_D2, 1024, 1, 0, 2048, 1);
      chk("R8 later ignored", pkt_accept, 0);
      chk("R8 rem_pkts", rem_pkts, 2);
      repeat (3) @(negedge clk);
      chk("R9 incomp sticky", incomp_irq, 1);
      pulse_clr(0, 1);
      chk("R9 incomp cleared", incomp_irq, 0);

      // R9 set wins over clear
      pulse_clr(0, 1);
      arm(2, 2048, 0);
      pulse_eof(1);
      chk("R9 set wins", incomp_irq, 1);
      chk("R2 re-arm valid clear", data_valid, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule